// File: doc/BRIEF.md
# Sleep and Halt Wake Controller

This block sits beside a processor core and governs its two low-power states. A decoded halt strobe parks the core in halt. The core clock keeps running in halt, and only the halt indicator changes. A decoded sleep strobe enters sleep, but only when the three power-mode control bits are all clear in that cycle. In sleep the block turns off the clock enables for the core and for the DMA engine, and it stops memory refresh. While the external bus is not granted to another master, it also asks the pad logic to hold the address lines and strobes high. Other on-chip peripherals are not affected.

Both states end on the same set of wake causes: a non-maskable request, an external interrupt line whose enable is set, or an internal peripheral request whose enable is set. Requests from sources that are disabled are ignored. The asynchronous requests (the non-maskable request and the three external lines) pass through a two-flop synchronizer first. When a wake occurs, the block raises a one-cycle resume pulse. The pulse carries the winning source and says whether the core should vector to that interrupt or fall through to the next instruction. The core clock is released one cycle after the wake decision. An active-low reset returns the block to run from any state, at once.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: In run state, a sleep strobe enters sleep at the next clock edge only if ioStopBit, modeBitA and modeBitB are all 0 in that cycle. If any of the three bits is 1, the strobe is ignored: coreClkEn and haltN stay 1.
- R2: coreClkEn and dmaClkEn are 0 in sleep and in the resume cycle that follows sleep. In all other states they are 1.
- R3: refreshEn is 0 exactly when dmaClkEn is 0, which is during sleep and its resume cycle.
- R4: busHoldHigh is 1 only in sleep (or its resume cycle) while busGranted is 0. haltN is 0 in halt, in sleep and in either resume cycle, and 1 in run.
- R5: A wake comes from nmiReq, from extReq[k] when extEnable[k] is 1, or from intReq[i] when intEnable[i] is 1. A request whose enable is 0 leaves the low-power state and the resume outputs unchanged.
- R6: resumeValid is a one-cycle pulse, raised at the edge after the wake decision. The block returns to run at the following edge, and that is when coreClkEn rises after sleep.
- R7: resumeVector is 1 when gie was 1 at the wake decision or when the winner is the non-maskable request. Otherwise it is 0, meaning fall through to the next instruction. The value holds until the next wake.
- R8: In run state a halt strobe enters halt. In halt, coreClkEn, dmaClkEn and refreshEn stay 1 and busHoldHigh stays 0. Halt ends on the same wake causes, with the same resume pulse.
- R9: resumeSrc reports the highest-priority active enabled source. The codes are: 0 for the non-maskable request, 1, 2 and 3 for external lines 0, 1 and 2, and 4+i for internal source i. A lower code wins.
- R10: nmiReq and extReq are synchronized through two flops. A request first seen at edge k makes resumeValid high after edge k+2, not after edge k+1. intReq is used without delay.
- R11: rstN low forces run state at once, with clocks enabled, haltN 1 and resumeValid, resumeVector and resumeSrc all 0.
- R12: If the sleep and halt strobes come together and sleep is allowed, sleep wins. Strobes that arrive while the block is in halt, sleep or a resume cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sleepStrobe | input | 1 | Decoded sleep instruction, one cycle |
| haltStrobe | input | 1 | Decoded halt instruction, one cycle |
| ioStopBit | input | 1 | I/O stop control bit |
| modeBitA | input | 1 | First power-mode control bit |
| modeBitB | input | 1 | Second power-mode control bit |
| gie | input | 1 | Global interrupt enable |
| intEnable | input | NUM_INT | Per-source enables for internal requests |
| extEnable | input | 3 | Enables for the external interrupt lines |
| nmiReq | input | 1 | Non-maskable request, asynchronous |
| extReq | input | 3 | External interrupt lines, asynchronous |
| intReq | input | NUM_INT | Internal peripheral requests, synchronous |
| busGranted | input | 1 | External master holds the bus |
| coreClkEn | output | 1 | Clock enable for the core |
| dmaClkEn | output | 1 | Clock enable for the DMA engine |
| refreshEn | output | 1 | Memory refresh enable |
| busHoldHigh | output | 1 | Drive address lines and strobes high |
| haltN | output | 1 | Halt indicator, active low |
| resumeValid | output | 1 | One-cycle resume pulse |
| resumeVector | output | 1 | 1 = take the interrupt, 0 = fall through |
| resumeSrc | output | SRC_W | Code of the winning wake source |

## Verification
A wrong state register shows up at the ports within one clock. All of coreClkEn, dmaClkEn, refreshEn, busHoldHigh and haltN are decoded directly from the state, so a missed entry or a spurious exit changes them at the next edge. A synchronizer of the wrong depth shifts the resume pulse by a cycle relative to the external request. A faulty priority encoder or capture register shows as a wrong resumeSrc or resumeVector in that same pulse cycle. Because every output is compared against a reference model at every cycle, a fault is reported at the first cycle in which it is visible.

// File: rtl/swc_pkg.sv
package swc_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_HALT,
    ST_SLEEP,
    ST_WAKE_SLEEP,
    ST_WAKE_HALT
  } swcState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // wake decided this cycle: latch resume information
  } swcStrobe_t;

  localparam int EXT_LINES = 3;

endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] qOut
);

  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[g] <= '0;
        else       pipe[g] <= dIn;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[g] <= '0;
        else       pipe[g] <= pipe[g-1];
      end
    end
  end

  assign qOut = pipe[STAGES-1];

endmodule

// File: rtl/swc_datapath.sv
module swc_datapath
  import swc_pkg::*;
#(
  parameter int NUM_INT     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int SRC_W       = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 nmiReq,
  input  logic [EXT_LINES-1:0] extReq,
  input  logic [EXT_LINES-1:0] extEnable,
  input  logic [NUM_INT-1:0]   intReq,
  input  logic [NUM_INT-1:0]   intEnable,
  input  logic                 gie,
  input  swcStrobe_t           strobe,
  output logic                 wakeAny,
  output logic                 resumeValid,
  output logic                 resumeVector,
  output logic [SRC_W-1:0]     resumeSrc
);

  localparam int NUM_SRC  = NUM_INT + EXT_LINES + 1;
  localparam int ASYNC_W  = EXT_LINES + 1;

  logic [ASYNC_W-1:0] asyncSynced;
  logic [NUM_SRC-1:0] srcVec;
  logic [SRC_W-1:0]   pickSrc;

  swc_sync #(.WIDTH(ASYNC_W), .STAGES(SYNC_STAGES)) syncAsync_i (
    .clk  (clk),
    .rstN (rstN),
    .dIn  ({extReq, nmiReq}),
    .qOut (asyncSynced)
  );

  // Index 0 is the non-maskable request, then external lines, then internal
  assign srcVec = {intReq & intEnable,
                   asyncSynced[ASYNC_W-1:1] & extEnable,
                   asyncSynced[0]};

  assign wakeAny = |srcVec;

  always_comb begin
    pickSrc = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (srcVec[i]) pickSrc = SRC_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resumeValid  <= 1'b0;
      resumeVector <= 1'b0;
      resumeSrc    <= '0;
    end else begin
      resumeValid <= strobe.capture;
      if (strobe.capture) begin
        resumeSrc    <= pickSrc;
        resumeVector <= gie | srcVec[0];
      end
    end
  end

endmodule

// File: rtl/swc_control.sv
module swc_control
  import swc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepStrobe,
  input  logic       haltStrobe,
  input  logic       ioStopBit,
  input  logic       modeBitA,
  input  logic       modeBitB,
  input  logic       busGranted,
  input  logic       wakeAny,
  output swcStrobe_t strobe,
  output logic       coreClkEn,
  output logic       dmaClkEn,
  output logic       refreshEn,
  output logic       busHoldHigh,
  output logic       haltN
);

  swcState_t stateQ, stateD;
  logic      sleepAllowed;
  logic      inSleep;
  logic      parked;

  assign sleepAllowed = sleepStrobe & ~ioStopBit & ~modeBitA & ~modeBitB;
  assign parked       = (stateQ == ST_SLEEP) || (stateQ == ST_HALT);

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_RUN: begin
        if (sleepAllowed)    stateD = ST_SLEEP;
        else if (haltStrobe) stateD = ST_HALT;
      end
      ST_SLEEP:      if (wakeAny) stateD = ST_WAKE_SLEEP;
      ST_HALT:       if (wakeAny) stateD = ST_WAKE_HALT;
      ST_WAKE_SLEEP: stateD = ST_RUN;
      ST_WAKE_HALT:  stateD = ST_RUN;
      default:       stateD = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_RUN;
    else       stateQ <= stateD;
  end

  assign strobe.capture = parked & wakeAny;

  assign inSleep     = (stateQ == ST_SLEEP) || (stateQ == ST_WAKE_SLEEP);
  assign coreClkEn   = ~inSleep;
  assign dmaClkEn    = ~inSleep;
  assign refreshEn   = ~inSleep;
  assign busHoldHigh = inSleep & ~busGranted;
  assign haltN       = (stateQ == ST_RUN);

endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import swc_pkg::*;
#(
  parameter int NUM_INT     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int SRC_W       = $clog2(NUM_INT + EXT_LINES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sleepStrobe,
  input  logic                 haltStrobe,
  input  logic                 ioStopBit,
  input  logic                 modeBitA,
  input  logic                 modeBitB,
  input  logic                 gie,
  input  logic [NUM_INT-1:0]   intEnable,
  input  logic [EXT_LINES-1:0] extEnable,
  input  logic                 nmiReq,
  input  logic [EXT_LINES-1:0] extReq,
  input  logic [NUM_INT-1:0]   intReq,
  input  logic                 busGranted,
  output logic                 coreClkEn,
  output logic                 dmaClkEn,
  output logic                 refreshEn,
  output logic                 busHoldHigh,
  output logic                 haltN,
  output logic                 resumeValid,
  output logic                 resumeVector,
  output logic [SRC_W-1:0]     resumeSrc
);

  swcStrobe_t strobe;
  logic       wakeAny;

  swc_control control_i (
    .clk         (clk),
    .rstN        (rstN),
    .sleepStrobe (sleepStrobe),
    .haltStrobe  (haltStrobe),
    .ioStopBit   (ioStopBit),
    .modeBitA    (modeBitA),
    .modeBitB    (modeBitB),
    .busGranted  (busGranted),
    .wakeAny     (wakeAny),
    .strobe      (strobe),
    .coreClkEn   (coreClkEn),
    .dmaClkEn    (dmaClkEn),
    .refreshEn   (refreshEn),
    .busHoldHigh (busHoldHigh),
    .haltN       (haltN)
  );

  swc_datapath #(
    .NUM_INT     (NUM_INT),
    .SYNC_STAGES (SYNC_STAGES),
    .SRC_W       (SRC_W)
  ) datapath_i (
    .clk          (clk),
    .rstN         (rstN),
    .nmiReq       (nmiReq),
    .extReq       (extReq),
    .extEnable    (extEnable),
    .intReq       (intReq),
    .intEnable    (intEnable),
    .gie          (gie),
    .strobe       (strobe),
    .wakeAny      (wakeAny),
    .resumeValid  (resumeValid),
    .resumeVector (resumeVector),
    .resumeSrc    (resumeSrc)
  );

endmodule

// File: rtl/sleep_wake_ctrl_chk.sv
module sleep_wake_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic sleepStrobe,
  input logic haltStrobe,
  input logic ioStopBit,
  input logic modeBitA,
  input logic modeBitB,
  input logic gie,
  input logic busGranted,
  input logic coreClkEn,
  input logic dmaClkEn,
  input logic refreshEn,
  input logic busHoldHigh,
  input logic haltN,
  input logic resumeValid,
  input logic resumeVector
);

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (haltN && sleepStrobe && !ioStopBit && !modeBitA && !modeBitB) |=> !coreClkEn); // R1

  AST_SLEEP_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (haltN && sleepStrobe && (ioStopBit || modeBitA || modeBitB) && !haltStrobe)
      |=> (haltN && coreClkEn)); // R1

  AST_REFRESH_WITH_DMA: assert property (@(posedge clk) disable iff (!rstN)
    !refreshEn |-> (!dmaClkEn && !coreClkEn)); // R3

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busHoldHigh |-> (!busGranted && !haltN && !coreClkEn)); // R4

  AST_RESUME_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    resumeValid |=> !resumeValid); // R6

  AST_CLK_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (resumeValid && !coreClkEn) |=> (coreClkEn && haltN)); // R6

  AST_VECTOR_GIE: assert property (@(posedge clk) disable iff (!rstN)
    (resumeValid && $past(gie)) |-> resumeVector); // R7

  AST_HALT_CLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (!haltN && coreClkEn) |-> (dmaClkEn && refreshEn && !busHoldHigh)); // R8

endmodule

bind sleep_wake_ctrl sleep_wake_ctrl_chk chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .sleepStrobe  (sleepStrobe),
  .haltStrobe   (haltStrobe),
  .ioStopBit    (ioStopBit),
  .modeBitA     (modeBitA),
  .modeBitB     (modeBitB),
  .gie          (gie),
  .busGranted   (busGranted),
  .coreClkEn    (coreClkEn),
  .dmaClkEn     (dmaClkEn),
  .refreshEn    (refreshEn),
  .busHoldHigh  (busHoldHigh),
  .haltN        (haltN),
  .resumeValid  (resumeValid),
  .resumeVector (resumeVector)
);

// File: tb/sleep_wake_ctrl_tb_top.sv
module sleep_wake_ctrl_tb_top;

  localparam int NI    = 4;
  localparam int NSRC  = NI + 4;
  localparam int SW    = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepStrobe = 0, haltStrobe = 0, ioStopBit = 0, modeBitA = 0, modeBitB = 0;
  logic gie = 0, nmiReq = 0, busGranted = 0;
  logic [NI-1:0] intEnable = '0, intReq = '0;
  logic [2:0] extEnable = '0, extReq = '0;
  logic coreClkEn, dmaClkEn, refreshEn, busHoldHigh, haltN, resumeValid, resumeVector;
  logic [SW-1:0] resumeSrc;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sleep_wake_ctrl #(.NUM_INT(NI)) dut_i (
    .clk(clk), .rstN(rstN), .sleepStrobe(sleepStrobe), .haltStrobe(haltStrobe),
    .ioStopBit(ioStopBit), .modeBitA(modeBitA), .modeBitB(modeBitB), .gie(gie),
    .intEnable(intEnable), .extEnable(extEnable), .nmiReq(nmiReq), .extReq(extReq),
    .intReq(intReq), .busGranted(busGranted), .coreClkEn(coreClkEn),
    .dmaClkEn(dmaClkEn), .refreshEn(refreshEn), .busHoldHigh(busHoldHigh),
    .haltN(haltN), .resumeValid(resumeValid), .resumeVector(resumeVector),
    .resumeSrc(resumeSrc)
  );

  // Reference model: 0 run, 1 halt, 2 sleep, 3 resume after sleep, 4 resume after halt
  int mState = 0;
  logic mNmi1 = 0, mNmi2 = 0;
  logic [2:0] mExt1 = '0, mExt2 = '0;
  logic mRv = 0, mVec = 0;
  logic [SW-1:0] mSrc = '0;

  function automatic logic [SW-1:0] firstSet(input logic [NSRC-1:0] v);
    for (int i = 0; i < NSRC; i++) if (v[i]) return SW'(i);
    return '0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    logic [NSRC-1:0] srcs;
    logic cap;
    if (!rstN) begin
      mState = 0; mNmi1 = 0; mNmi2 = 0; mExt1 = '0; mExt2 = '0;
      mRv = 0; mVec = 0; mSrc = '0;
    end else begin
      srcs = {intReq & intEnable, mExt2 & extEnable, mNmi2};
      cap = 0;
      case (mState)
        0: if (sleepStrobe && !ioStopBit && !modeBitA && !modeBitB) mState = 2;
           else if (haltStrobe) mState = 1;
        1: if (|srcs) begin cap = 1; mState = 4; end
        2: if (|srcs) begin cap = 1; mState = 3; end
        default: mState = 0;
      endcase
      mRv = cap;
      if (cap) begin
        mSrc = firstSet(srcs);
        mVec = gie | srcs[0];
      end
      mNmi2 = mNmi1; mNmi1 = nmiReq;
      mExt2 = mExt1; mExt1 = extReq;
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic slp;
    slp = (mState == 2) || (mState == 3);
    chk(8'(coreClkEn), 8'(!slp), "R2 coreClkEn");
    chk(8'(dmaClkEn), 8'(!slp), "R2 dmaClkEn");
    chk(8'(refreshEn), 8'(!slp), "R3 refreshEn");
    chk(8'(busHoldHigh), 8'(slp && !busGranted), "R4 busHoldHigh");
    chk(8'(haltN), 8'(mState == 0), "R4 haltN");
    chk(8'(resumeValid), 8'(mRv), "R6 resumeValid");
    chk(8'(resumeVector), 8'(mVec), "R7 resumeVector");
    chk(8'(resumeSrc), 8'(mSrc), "R9 resumeSrc");
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareAll();
    end
  endtask

  task automatic clearIns();
    sleepStrobe = 0; haltStrobe = 0; ioStopBit = 0; modeBitA = 0; modeBitB = 0;
    nmiReq = 0; extReq = '0; intReq = '0; intEnable = '0; extEnable = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd731));
    step(2);
    // R11: reset values
    chk(8'(coreClkEn), 8'd1, "R11 reset coreClkEn");
    chk(8'(haltN), 8'd1, "R11 reset haltN");
    chk(8'(resumeValid), 8'd0, "R11 reset resumeValid");
    rstN = 1;
    step(2);

    // R1: blocked sleep entry
    ioStopBit = 1; sleepStrobe = 1; step(1);
    sleepStrobe = 0; ioStopBit = 0;
    chk(8'(coreClkEn), 8'd1, "R1 blocked sleep keeps clock");
    modeBitB = 1; sleepStrobe = 1; step(1);
    sleepStrobe = 0; modeBitB = 0;
    chk(8'(haltN), 8'd1, "R1 blocked sleep keeps run");

    // R1 / R2 / R3 / R4: sleep entry
    sleepStrobe = 1; step(1); sleepStrobe = 0;
    chk(8'(coreClkEn), 8'd0, "R2 sleep gates core");
    chk(8'(refreshEn), 8'd0, "R3 sleep stops refresh");
    chk(8'(busHoldHigh), 8'd1, "R4 bus held high");
    busGranted = 1; step(1);
    chk(8'(busHoldHigh), 8'd0, "R4 granted bus not held");
    busGranted = 0;

    // R5: disabled sources do nothing
    intReq = 4'b0110; extReq = 3'b101; step(5);
    chk(8'(coreClkEn), 8'd0, "R5 disabled source no wake");
    chk(8'(resumeValid), 8'd0, "R5 no resume pulse");
    intReq = '0; extReq = '0; step(3);

    // R10 / R7 / R9: external line 2, gie clear -> fall through, code 3
    gie = 0; extEnable = 3'b100; extReq = 3'b100;
    step(2);
    chk(8'(resumeValid), 8'd0, "R10 not yet synchronized");
    step(1);
    chk(8'(resumeValid), 8'd1, "R10 pulse after sync");
    chk(8'(resumeVector), 8'd0, "R7 fall through with gie clear");
    chk(8'(resumeSrc), 8'd3, "R9 ext line 2 code");
    chk(8'(coreClkEn), 8'd0, "R6 clock still gated in resume cycle");
    extReq = '0; step(1);
    chk(8'(coreClkEn), 8'd1, "R6 clock released");
    chk(8'(resumeValid), 8'd0, "R6 single pulse");
    clearIns(); step(3);

    // R9: ext line 1 beats internal 2 when enabled together
    sleepStrobe = 1; step(1); sleepStrobe = 0;
    gie = 1; extReq = 3'b010; intReq = 4'b0100; step(3);
    extEnable = 3'b010; intEnable = 4'b0100; step(1);
    chk(8'(resumeSrc), 8'd2, "R9 ext1 over internal");
    chk(8'(resumeVector), 8'd1, "R7 vector with gie set");
    clearIns(); step(3);

    // R9 / R7: NMI beats ext0 and vectors even with gie clear
    gie = 0; sleepStrobe = 1; step(1); sleepStrobe = 0;
    nmiReq = 1; extReq = 3'b001; extEnable = 3'b001; step(3);
    chk(8'(resumeSrc), 8'd0, "R9 NMI highest");
    chk(8'(resumeVector), 8'd1, "R7 NMI always vectors");
    clearIns(); step(3);

    // R8: halt keeps clocks, exits on internal 3
    haltStrobe = 1; step(1); haltStrobe = 0;
    chk(8'(haltN), 8'd0, "R8 halt indicator");
    chk(8'(coreClkEn), 8'd1, "R8 clock runs in halt");
    sleepStrobe = 1; step(1); sleepStrobe = 0;
    chk(8'(coreClkEn), 8'd1, "R12 sleep strobe ignored in halt");
    intEnable = 4'b1000; intReq = 4'b1000; step(1);
    chk(8'(resumeValid), 8'd1, "R8 halt resume pulse");
    chk(8'(resumeSrc), 8'd7, "R9 internal 3 code");
    clearIns(); step(3);

    // R12: both strobes -> sleep
    sleepStrobe = 1; haltStrobe = 1; step(1); sleepStrobe = 0; haltStrobe = 0;
    chk(8'(coreClkEn), 8'd0, "R12 sleep wins");
    // R11: reset during sleep
    rstN = 0; #1;
    chk(8'(coreClkEn), 8'd1, "R11 reset exits sleep");
    chk(8'(resumeSrc), 8'd0, "R11 reset clears source");
    step(1); rstN = 1; step(1);

    // Random phase
    for (int c = 0; c < 4000; c++) begin
      sleepStrobe = ($urandom % 5) == 0;
      haltStrobe  = ($urandom % 8) == 0;
      ioStopBit   = ($urandom % 6) == 0;
      modeBitA    = ($urandom % 6) == 0;
      modeBitB    = ($urandom % 6) == 0;
      gie         = $urandom % 2;
      busGranted  = ($urandom % 3) == 0;
      if (($urandom % 16) == 0) begin
        intEnable = NI'($urandom);
        extEnable = 3'($urandom);
      end
      nmiReq = ($urandom % 40) == 0;
      for (int k = 0; k < 3; k++) extReq[k] = ($urandom % 14) == 0;
      for (int k = 0; k < NI; k++) intReq[k] = ($urandom % 18) == 0;
      if (($urandom % 500) == 0) begin
        rstN = 0; step(1); rstN = 1;
      end
      step(1);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule